// File: doc/BRIEF.md
# Scanline Interrupt Counter

This block counts rendered video scanlines and raises a level interrupt toward the CPU once a programmed number of lines has passed. The video side supplies three inputs: a single-cycle pulse for each scanline, the number of that line, and a flag that is high while rendering is on. A line counts only when it falls in the visible range and rendering is on.

The CPU programs the block with single-cycle writes. The write address is masked with 0xF007 before it is decoded, so bits 11:3 do not select anything. Three masked addresses have an effect: one disables the block and clears the interrupt, one enables the block, and one stores an 8-bit reload value. Enabling the block and writing the reload value both set a pending-reload flag. The flag does not load the counter at once. The counter takes the reload value on the next counted line and then steps that same line.

Once the counter has reached zero, the interrupt asserts on every counted line while the block is enabled. The interrupt is a registered level. Only the disable write or reset clears it.

Top module: `scanline_irq_counter`

## Requirements
- R1: After reset (rst_ni low), irq_o is 0 and the enable, counter, reload value and pending-reload flag are all 0.
- R2: A write with wr_en_i high is decoded from wr_addr_i & 0xF007. Address bits 11:3 have no effect on which action is taken.
- R3: A write whose masked address is 0xC002 clears the enable and drives irq_o to 0 from the next cycle. It leaves the counter, the reload value and the pending flag unchanged.
- R4: A write whose masked address is 0xC003 sets the enable and sets the pending-reload flag.
- R5: A write whose masked address is 0xC005 stores wr_data_i as the reload value and sets the pending-reload flag.
- R6: A line is counted only in a cycle where line_pulse_i is high, line_num_i is at most 239 and render_en_i is high. An uncounted pulse changes neither the counter nor irq_o.
- R7: On a counted line with the pending flag set, the counter first takes the reload value and the flag clears. In either case, the counter then decrements if it is nonzero and stays at zero if it is zero.
- R8: If the counter is zero after the step of a counted line and the block is enabled, irq_o is 1 from the next cycle. irq_o then stays 1 until a 0xC002 write or reset.
- R9: Writes to any other masked address, including 0xC004 and 0xC006, change no state.
- R10: When a write and a counted line fall in the same cycle, the line step uses the state from before the write. The fields that the write sets take the written values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | CPU write strobe, one cycle |
| wr_addr_i | input | 16 | CPU write address |
| wr_data_i | input | 8 | CPU write data |
| line_pulse_i | input | 1 | One-cycle pulse per scanline |
| line_num_i | input | 9 | Number of the current scanline |
| render_en_i | input | 1 | Rendering enabled |
| irq_o | output | 1 | Interrupt request, level |

## Verification
The bench writes a reload value of zero and then enables the block. The interrupt must fire on the very first counted line. A design that decremented before loading would wrap to 255 and stay silent. The bench also writes a new reload value while the counter is still running. A design that loaded immediately instead of deferring would fire one line early or late. Other checks send pulses for line 240 and above, pulses with rendering off, and aliased addresses whose bits 11:3 are set. A design with loose line or address gating would count or decode those. The bench also confirms that the interrupt stays asserted after the counter would otherwise change. A design that cleared it on its own would drop it too early.

// File: rtl/scirq_pkg.sv
package scirq_pkg;
  typedef logic [15:0] addr_t;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_DISABLE,
    OP_ENABLE,
    OP_RELOAD
  } wr_op_e;

  localparam addr_t ADDR_MASK  = 16'hF007;
  localparam addr_t ADDR_DIS   = 16'hC002;
  localparam addr_t ADDR_ENA   = 16'hC003;
  localparam addr_t ADDR_RLD   = 16'hC005;
endpackage

// File: rtl/scirq_decode.sv
module scirq_decode
  import scirq_pkg::*;
(
  input  logic   wr_en_i,
  input  addr_t  wr_addr_i,
  output wr_op_e op_o
);
  addr_t masked;
  assign masked = wr_addr_i & ADDR_MASK;

  always_comb begin
    op_o = OP_NONE;
    if (wr_en_i) begin
      case (masked)
        ADDR_DIS: op_o = OP_DISABLE;
        ADDR_ENA: op_o = OP_ENABLE;
        ADDR_RLD: op_o = OP_RELOAD;
        default:  op_o = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/scirq_line_gate.sv
module scirq_line_gate #(
  parameter int LINE_W    = 9,
  parameter int LAST_LINE = 239
) (
  input  logic              line_pulse_i,
  input  logic [LINE_W-1:0] line_num_i,
  input  logic              render_en_i,
  output logic              count_o
);
  localparam logic [LINE_W-1:0] LastLine = LINE_W'(LAST_LINE);

  assign count_o = line_pulse_i && render_en_i && (line_num_i <= LastLine);
endmodule

// File: rtl/scirq_counter.sv
module scirq_counter
  import scirq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  wr_op_e           op_i,
  input  logic [CNT_W-1:0] data_i,
  input  logic             step_i,
  output logic             irq_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] latch_o
);
  logic             en_q, pend_q, irq_q;
  logic [CNT_W-1:0] cnt_q, latch_q;
  logic [CNT_W-1:0] staged, stepped;

  // load from the reload value first, then decrement without wrapping
  always_comb begin
    staged  = pend_q ? latch_q : cnt_q;
    stepped = (staged != '0) ? staged - 1'b1 : staged;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      pend_q  <= 1'b0;
      irq_q   <= 1'b0;
      cnt_q   <= '0;
      latch_q <= '0;
    end else begin
      if (step_i) begin
        cnt_q  <= stepped;
        pend_q <= 1'b0;
        if (en_q && stepped == '0) irq_q <= 1'b1;
      end
      // writes come later in the block, so they win over the line step
      case (op_i)
        OP_DISABLE: begin
          en_q  <= 1'b0;
          irq_q <= 1'b0;
        end
        OP_ENABLE: begin
          en_q   <= 1'b1;
          pend_q <= 1'b1;
        end
        OP_RELOAD: begin
          latch_q <= data_i;
          pend_q  <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign irq_o   = irq_q;
  assign cnt_o   = cnt_q;
  assign latch_o = latch_q;
endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter
  import scirq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int LINE_W    = 9,
  parameter int LAST_LINE = 239
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [15:0]       wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              line_pulse_i,
  input  logic [LINE_W-1:0] line_num_i,
  input  logic              render_en_i,
  output logic              irq_o
);
  wr_op_e            op;
  logic              step;
  logic [DATA_W-1:0] cnt_q, latch_q;

  scirq_decode u_decode (
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .op_o      (op)
  );

  scirq_line_gate #(
    .LINE_W    (LINE_W),
    .LAST_LINE (LAST_LINE)
  ) u_gate (
    .line_pulse_i (line_pulse_i),
    .line_num_i   (line_num_i),
    .render_en_i  (render_en_i),
    .count_o      (step)
  );

  scirq_counter #(
    .CNT_W (DATA_W)
  ) u_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .data_i  (wr_data_i),
    .step_i  (step),
    .irq_o   (irq_o),
    .cnt_o   (cnt_q),
    .latch_o (latch_q)
  );
endmodule

// File: rtl/scirq_checker.sv
module scirq_checker #(
  parameter int DATA_W    = 8,
  parameter int LINE_W    = 9,
  parameter int LAST_LINE = 239
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [15:0]       wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              line_pulse_i,
  input logic [LINE_W-1:0] line_num_i,
  input logic              render_en_i,
  input logic              irq_o,
  input logic [DATA_W-1:0] cnt_q,
  input logic [DATA_W-1:0] latch_q
);
  localparam logic [LINE_W-1:0] LastLine = LINE_W'(LAST_LINE);

  logic counted, wr_dis, wr_rld;
  assign counted = line_pulse_i && render_en_i && (line_num_i <= LastLine);
  assign wr_dis  = wr_en_i && ((wr_addr_i & 16'hF007) == 16'hC002);
  assign wr_rld  = wr_en_i && ((wr_addr_i & 16'hF007) == 16'hC005);

  a_r3_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dis |=> !irq_o);

  a_r5_reload_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_rld |=> latch_q == $past(wr_data_i));

  a_r6_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!counted && !wr_en_i) |=> ($stable(cnt_q) && $stable(irq_o)));

  a_r8_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !wr_dis) |=> irq_o);

  a_r8_rise_on_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(counted));
endmodule

bind scanline_irq_counter scirq_checker #(
  .DATA_W    (DATA_W),
  .LINE_W    (LINE_W),
  .LAST_LINE (LAST_LINE)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_addr_i    (wr_addr_i),
  .wr_data_i    (wr_data_i),
  .line_pulse_i (line_pulse_i),
  .line_num_i   (line_num_i),
  .render_en_i  (render_en_i),
  .irq_o        (irq_o),
  .cnt_q        (cnt_q),
  .latch_q      (latch_q)
);

// File: tb/scanline_irq_counter_bench.sv
module scanline_irq_counter_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [15:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       line_pulse_i = 1'b0;
  logic [8:0] line_num_i = '0;
  logic       render_en_i = 1'b0;
  logic       irq_o;

  int checks = 0;
  int errors = 0;

  // reference state
  bit       m_en, m_pend, m_irq;
  bit [7:0] m_cnt, m_latch;

  always #2.5 clk_i = ~clk_i;

  scanline_irq_counter u_scanline_irq_counter (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .line_pulse_i, .line_num_i, .render_en_i, .irq_o
  );

  function automatic bit is_counted(input bit [8:0] num, input bit ren);
    return ren && (num <= 9'd239);
  endfunction

  function automatic bit [15:0] alias_addr(input bit [15:0] base);
    return base | 16'({$urandom_range(0, 511)} << 3);
  endfunction

  task automatic check(input string req, input bit exp);
    checks++;
    if (irq_o !== exp) begin
      errors++;
      $display("FAIL %s: irq_o=%0b expected=%0b", req, irq_o, exp);
    end
  endtask

  task automatic model_write(input bit [15:0] a, input bit [7:0] d);
    case (a & 16'hF007)
      16'hC002: begin m_en = 0; m_irq = 0; end
      16'hC003: begin m_en = 1; m_pend = 1; end
      16'hC005: begin m_latch = d; m_pend = 1; end
      default: ;
    endcase
  endtask

  task automatic model_line(input bit [8:0] num, input bit ren);
    bit [7:0] s;
    if (!is_counted(num, ren)) return;
    s = m_pend ? m_latch : m_cnt;
    if (s != 0) s = s - 1;
    m_cnt = s;
    m_pend = 0;
    if (m_en && s == 0) m_irq = 1;
  endtask

  task automatic do_write(input bit [15:0] a, input bit [7:0] d, input string req);
    @(negedge clk_i);
    wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 0;
    model_write(a, d);
    check(req, m_irq);
  endtask

  task automatic do_line(input bit [8:0] num, input bit ren, input string req);
    @(negedge clk_i);
    line_pulse_i = 1; line_num_i = num; render_en_i = ren;
    @(negedge clk_i);
    line_pulse_i = 0;
    model_line(num, ren);
    check(req, m_irq);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h5C1A_0090));
    repeat (3) @(negedge clk_i);
    check("R1 reset", 1'b0);
    rst_ni = 1;
    @(negedge clk_i);
    check("R1 after release", 1'b0);

    // R7/R8: zero reload with enable fires on the first counted line
    do_write(16'hC005, 8'd0, "R5 reload zero");
    do_write(16'hC003, 8'd0, "R4 enable");
    do_line(9'd10, 1, "R7 R8 zero reload fires");
    do_line(9'd11, 1, "R8 stays asserted");
    do_write(16'hC002, 8'd0, "R3 disable clears");

    // R7: count of 3 -> fires on third counted line
    do_write(16'hC005, 8'd3, "R5 reload 3");
    do_write(16'hC003, 8'd0, "R4 enable");
    do_line(9'd0, 1, "R7 load and step");
    do_line(9'd240, 1, "R6 line 240 ignored");
    do_line(9'd5, 0, "R6 render off ignored");
    do_line(9'd1, 1, "R7 step");
    do_line(9'd239, 1, "R8 fires at zero, line 239 counts");
    do_write(16'hC004, 8'hFF, "R9 C004 ignored");
    do_write(16'hC006, 8'hFF, "R9 C006 ignored");
    do_write(alias_addr(16'hC002), 8'd0, "R2 aliased disable");

    // R7: deferred reload while running
    do_write(alias_addr(16'hC005), 8'd4, "R2 aliased reload");
    do_write(16'hC003, 8'd0, "R4 enable");
    do_line(9'd20, 1, "R7 load 4 step");
    do_write(16'hC005, 8'd1, "R7 reload deferred");
    do_line(9'd21, 1, "R7 reload 1 fires");
    do_write(16'hC002, 8'd0, "R3 disable");
    do_line(9'd22, 1, "R8 disabled no irq");

    // R10: write and counted line in the same cycle
    do_write(16'hC005, 8'd0, "R5 reload zero");
    @(negedge clk_i);
    wr_en_i = 1; wr_addr_i = 16'hC003; wr_data_i = 0;
    line_pulse_i = 1; line_num_i = 9'd30; render_en_i = 1;
    @(negedge clk_i);
    wr_en_i = 0; line_pulse_i = 0;
    model_line(9'd30, 1);      // step uses pre-write (disabled) state
    model_write(16'hC003, 0);
    check("R10 same-cycle step uses old enable", m_irq);
    do_line(9'd31, 1, "R10 pending from write survives");
    do_write(16'hC002, 8'd0, "R3 disable");

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      int sel = $urandom_range(0, 99);
      if (sel < 8)       do_write(alias_addr(16'hC002), 8'($urandom), "R3 rand disable");
      else if (sel < 16) do_write(alias_addr(16'hC003), 8'($urandom), "R4 rand enable");
      else if (sel < 26) do_write(alias_addr(16'hC005), 8'($urandom_range(0, 6)), "R5 rand reload");
      else if (sel < 32) do_write(16'($urandom), 8'($urandom), "R9 rand other write");
      else if (sel < 40) do_line(9'($urandom_range(240, 511)), 1'($urandom), "R6 rand off-screen");
      else if (sel < 46) do_line(9'($urandom_range(0, 239)), 1'b0, "R6 rand render off");
      else               do_line(9'($urandom_range(0, 239)), 1'b1, "R7 R8 rand line");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule